// File: doc/BRIEF.md
# Pulse-Pause Downlink Bit Transmitter

This block sends one reader-to-card command frame by switching a coil drive line between carrier on (open) and carrier off (shorted). A frame holds 1 to `MAX_BITS` bits taken from a data word, least significant bit first. Every bit opens with a fixed carrier-off pause and continues with carrier on. The length of the whole pause-plus-carrier interval gives the bit value: a long interval is a one and a short interval is a zero. After the last bit one more pause marks the end of the frame, and then the carrier comes back on.

All durations are whole ticks of a prescaled timebase. A tick is `CLK_DIV` system clocks, so a 48 MHz clock divided by 32 gives a 1.5 MHz tick. A free-running tick counter supplies the timestamp. The value it holds at the moment the final pause ends is latched as the frame-stop time, and a later receive window can be timed from it. The data arrives already whitened; the block only times it.

Top module: `ppe_downlink_tx`

## Requirements
- R1: A tick counter starts at 0 out of reset and increments once every `CLK_DIV` clock cycles. Every coil segment lasts a whole number of ticks, and the coil changes only on a tick edge.
- R2: Each bit starts with `coil_open`=0 (coil shorted) for exactly `PAUSE_TICKS` ticks (default 30). After that `coil_open`=1.
- R3: A one bit lasts `ONE_TICKS` ticks in total (default 120), counted from the start of its pause to the start of the next pause. A zero bit lasts `ZERO_TICKS` ticks in total (default 60).
- R4: Bits go out LSB first, `data[0]` first. Exactly `nbits` bits are sent, and data bits at index `nbits` and above have no effect.
- R5: After the last bit, one more pause of `PAUSE_TICKS` ticks with `coil_open`=0 is sent. Then `coil_open` returns to 1.
- R6: `done` is high for exactly one cycle, on the clock edge where the final pause ends. `busy` falls on that same edge.
- R7: `stop_time` takes the value of the tick counter at the edge where `done` rises, and holds it until the next frame ends.
- R8: A `start` that arrives while `busy`=1 is ignored. The frame in flight keeps its waveform, and no second frame follows it.
- R9: A `start` with `nbits`=0 or `nbits`>`MAX_BITS` is rejected. In that case `busy` stays 0, `coil_open` stays 1, `done` does not pulse and `stop_time` does not change.
- R10: An accepted `start` sets `busy` on the next edge. While `busy`=0, `coil_open` is 1. Out of reset `coil_open`=1, `busy`=0, `done`=0 and `stop_time`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame request strobe |
| data | input | MAX_BITS | Frame bits, LSB sent first |
| nbits | input | $clog2(MAX_BITS)+1 | Number of bits to send |
| coil_open | output | 1 | 1 = carrier on, 0 = coil shorted (pause) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| stop_time | output | TS_W | Tick count latched at end of frame |

## Verification
The bench measures every low and high run of the coil line in clock cycles and decodes each bit from the length of its pause-plus-carrier interval. A design that sent the MSB first, or that took the bit value from the high time alone, would decode the wrong pattern. One that counted one bit too many or too few would show an extra or missing interval before the trailing pause. Frames that are all ones, all zeros, a single bit with the upper data bits set, and 32 bits are used to catch count off-by-ones and leakage from unused data bits. The bench fires a second strobe in the middle of a frame and then tries out-of-range bit counts. A design that restarted, queued the request, or produced pulses for a bad count would show up as a distorted waveform or as activity after `done`. `stop_time` is compared with an independent cycle count divided by the prescale, so a latch taken one tick early or late is caught.

// File: rtl/ppe_pkg.sv
package ppe_pkg;
  typedef enum logic [1:0] {
    S_IDLE,
    S_ALIGN,
    S_BIT,
    S_TAIL
  } seq_state_t;
endpackage

// File: rtl/ppe_tick_gen.sv
module ppe_tick_gen #(
  parameter int CLK_DIV = 32,
  parameter int TS_W    = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic            tick,
  output logic [TS_W-1:0] ts
);
  generate
    if (CLK_DIV > 1) begin : g_div
      localparam int DW = $clog2(CLK_DIV);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst)                            div_q <= '0;
        else if (div_q == DW'(CLK_DIV - 1)) div_q <= '0;
        else                                div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == DW'(CLK_DIV - 1));

      // R1
      tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       ts <= '0;
    else if (tick) ts <= ts + 1'b1;
  end
endmodule

// File: rtl/ppe_bit_seq.sv
module ppe_bit_seq
  import ppe_pkg::*;
#(
  parameter int PAUSE_TICKS = 30,
  parameter int ONE_TICKS   = 120,
  parameter int ZERO_TICKS  = 60,
  parameter int MAX_BITS    = 32,
  parameter int TS_W        = 32,
  parameter int CNT_W       = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic [TS_W-1:0]     ts,
  input  logic                start,
  input  logic [MAX_BITS-1:0] data,
  input  logic [CNT_W-1:0]    nbits,
  output logic                coil_open,
  output logic                busy,
  output logic                done,
  output logic [TS_W-1:0]     stop_time
);
  localparam int LONGEST = (ONE_TICKS > ZERO_TICKS) ? ONE_TICKS : ZERO_TICKS;
  localparam int LEN_W   = $clog2(LONGEST + 1);

  seq_state_t          state;
  logic [MAX_BITS-1:0] shreg;
  logic [CNT_W-1:0]    remain;
  logic [LEN_W-1:0]    seg_cnt;
  logic [LEN_W-1:0]    seg_nx;
  logic [LEN_W-1:0]    bit_len;
  logic                count_ok;

  assign count_ok = (nbits != '0) && (nbits <= CNT_W'(MAX_BITS));
  assign seg_nx   = seg_cnt + 1'b1;
  assign bit_len  = shreg[0] ? LEN_W'(ONE_TICKS) : LEN_W'(ZERO_TICKS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      shreg     <= '0;
      remain    <= '0;
      seg_cnt   <= '0;
      coil_open <= 1'b1;
      busy      <= 1'b0;
      done      <= 1'b0;
      stop_time <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start && count_ok) begin
            shreg  <= data;
            remain <= nbits;
            busy   <= 1'b1;
            state  <= S_ALIGN;
          end
        end
        S_ALIGN: begin
          if (tick) begin
            coil_open <= 1'b0;
            seg_cnt   <= '0;
            state     <= S_BIT;
          end
        end
        S_BIT: begin
          if (tick) begin
            if (seg_nx == bit_len) begin
              coil_open <= 1'b0;
              seg_cnt   <= '0;
              shreg     <= shreg >> 1;
              remain    <= remain - 1'b1;
              if (remain == CNT_W'(1)) state <= S_TAIL;
            end else begin
              if (seg_nx == LEN_W'(PAUSE_TICKS)) coil_open <= 1'b1;
              seg_cnt <= seg_nx;
            end
          end
        end
        S_TAIL: begin
          if (tick) begin
            if (seg_nx == LEN_W'(PAUSE_TICKS)) begin
              coil_open <= 1'b1;
              done      <= 1'b1;
              busy      <= 1'b0;
              stop_time <= ts + 1'b1;
              state     <= S_IDLE;
            end else begin
              seg_cnt <= seg_nx;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && nbits != '0 && nbits <= CNT_W'(MAX_BITS)) |=> busy);
  // R9
  reject_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (nbits == '0 || nbits > CNT_W'(MAX_BITS))) |=> !busy);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && coil_open));
  // R1
  coil_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(coil_open) |-> $past(tick));
  // R7
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(stop_time) |-> done);
  // R10
  idle_coil_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> coil_open);
endmodule

// File: rtl/ppe_downlink_tx.sv
module ppe_downlink_tx #(
  parameter int CLK_DIV     = 32,
  parameter int PAUSE_TICKS = 30,
  parameter int ONE_TICKS   = 120,
  parameter int ZERO_TICKS  = 60,
  parameter int MAX_BITS    = 32,
  parameter int TS_W        = 32,
  localparam int CNT_W      = $clog2(MAX_BITS) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [MAX_BITS-1:0] data,
  input  logic [CNT_W-1:0]    nbits,
  output logic                coil_open,
  output logic                busy,
  output logic                done,
  output logic [TS_W-1:0]     stop_time
);
  logic            tick;
  logic [TS_W-1:0] ts;

  ppe_tick_gen #(
    .CLK_DIV (CLK_DIV),
    .TS_W    (TS_W)
  ) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .ts   (ts)
  );

  ppe_bit_seq #(
    .PAUSE_TICKS (PAUSE_TICKS),
    .ONE_TICKS   (ONE_TICKS),
    .ZERO_TICKS  (ZERO_TICKS),
    .MAX_BITS    (MAX_BITS),
    .TS_W        (TS_W),
    .CNT_W       (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .ts        (ts),
    .start     (start),
    .data      (data),
    .nbits     (nbits),
    .coil_open (coil_open),
    .busy      (busy),
    .done      (done),
    .stop_time (stop_time)
  );
endmodule

// File: tb/ppe_downlink_tx_bench.sv
`timescale 1ns/1ps
module ppe_downlink_tx_bench;
  localparam int D    = 4;
  localparam int P    = 30;
  localparam int ONE  = 120;
  localparam int ZERO = 60;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] data = '0;
  logic [5:0]  nbits = '0;
  logic        coil_open, busy, done;
  logic [31:0] stop_time;
  int          cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  ppe_downlink_tx #(.CLK_DIV(D)) u_ppe_downlink_tx (
    .clk(clk), .rst(rst), .start(start), .data(data), .nbits(nbits),
    .coil_open(coil_open), .busy(busy), .done(done), .stop_time(stop_time)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_len(input logic lvl, output int len);
    len = 0;
    while (coil_open === lvl && len < 20000) begin
      len++;
      @(negedge clk);
    end
  endtask

  // Sends one frame and checks its whole waveform; poke>0 fires a stray start that many cycles in.
  task automatic frame(input logic [31:0] d, input int n, input int poke);
    int lo, hi, wait_c, bad;
    @(negedge clk);
    start = 1'b1; data = d; nbits = 6'(n);
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R10 busy after start", busy, 1);
    fork
      begin
        wait_c = 0;
        while (coil_open === 1'b1 && wait_c < 4 * D) begin wait_c++; @(negedge clk); end
        bad = 0;
        for (int i = 0; i < n; i++) begin
          run_len(1'b0, lo);
          run_len(1'b1, hi);
          if (lo != P * D) bad++;
          if (lo + hi != (d[i] ? ONE : ZERO) * D) bad++;
          if (i == 0) chk(lo == P * D, "R2 pause length", lo, P * D);
          if (i == 0) chk(lo + hi == (d[0] ? ONE : ZERO) * D, "R3 bit length", lo + hi, (d[0] ? ONE : ZERO) * D);
        end
        chk(bad == 0, "R4 LSB-first bit pattern", bad, 0);
        run_len(1'b0, lo);
        chk(lo == P * D, "R5 trailing pause", lo, P * D);
        chk(done === 1'b1 && busy === 1'b0, "R6 done with busy low", {done, busy}, 2);
        chk(stop_time == 32'(cyc / D), "R7 stop time", stop_time, cyc / D);
        @(negedge clk);
        chk(done === 1'b0, "R6 done one cycle", done, 0);
      end
      begin
        if (poke > 0) begin
          repeat (poke) @(negedge clk);
          start = 1'b1; data = ~d; nbits = 6'd5;
          @(negedge clk);
          start = 1'b0;
        end
      end
    join
  endtask

  task automatic t_reset();
    chk(coil_open === 1'b1 && busy === 1'b0 && done === 1'b0, "R10 reset outputs",
        {coil_open, busy, done}, 4);
    chk(stop_time == 0, "R10 reset stop time", stop_time, 0);
  endtask

  task automatic t_quiet(input int ncyc, input string req);
    int bad = 0;
    logic [31:0] st = stop_time;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (busy !== 1'b0 || coil_open !== 1'b1 || done !== 1'b0 || stop_time != st) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic t_reject(input int n);
    @(negedge clk);
    start = 1'b1; data = 32'hFFFF_FFFF; nbits = 6'(n);
    @(negedge clk);
    start = 1'b0;
    t_quiet(300, "R9 bad bit count rejected");
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    frame(32'h0000_000B, 4, 0);               // R3 mixed pattern
    frame(32'hFFFF_FFFF, 32, 0);              // R4 longest frame
    frame(32'h0000_0000, 32, 0);              // R3 all zero
    frame(32'hFFFF_FFFE, 1, 0);               // R4 upper bits ignored
    t_quiet(200, "R4 no extra bits after count");
    frame(32'hA5C3_0F96, 17, 0);              // R1 R7 arbitrary
    frame(32'h0000_0005, 3, 200);             // R8 stray start mid-frame
    t_quiet(600, "R8 stray start ignored");
    t_reject(0);
    t_reject(33);
    t_reject(63);
    frame(32'h0000_0001, 1, 0);               // R10 works after rejects
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule